// File: doc/BRIEF.md
# CPLD Macrocell with Selectable Output Enable

This block is one logic cell of a complex programmable device. A shared AND array hands it a vector of product terms. Five of those terms have fixed local jobs: asynchronous set, asynchronous clear, a local clock, data polarity and output enable. The remaining terms are OR-ed together under a per-cell allocation mask to form the cell's sum term.

The sum term is XOR-ed with the polarity term. The result either goes straight to the pin or passes through a storage element. That element acts as a D flip-flop or as a T flip-flop. It is clocked by the global clock, or by rising edges of the local clock term, which are sampled on the global clock. The cell output drives the pin and is also returned on a feedback port that the routing fabric sends to other cells.

A companion selector chooses the pin enable from one of four sources: the local enable term, one of the global enable lines, constant on, or constant off.

Top module: `cpld_macrocell`

## Requirements
- R1: While `rstN` is low, the register is cleared at once, without waiting for a clock edge, and the local clock edge tracker is cleared as well.
- R2: `ptIn` has this layout: bit 0 is set, bit 1 is clear, bit 2 is the local clock, bit 3 is polarity, bit 4 is the enable term, and bits 5 and up are the sum terms. The cell data value is the OR of the sum terms whose `cfgSumMask` bit is 1, XOR-ed with bit 3. A sum term whose mask bit is 0 has no effect.
- R3: When `cfgTMode`=0 and `cfgPtClk`=0, the register loads the cell data value at every rising edge of `clk`.
- R4: When `cfgCombOut`=1, `pinData` equals the cell data value and follows input changes without a clock edge. When `cfgCombOut`=0, `pinData` is the register.
- R5: When `cfgTMode`=1, the register inverts at a loading edge if the cell data value is 1, and holds if it is 0.
- R6: When `cfgPtClk`=1, the register loads only at a `clk` edge where `ptIn[2]` is 1 and was 0 at the previous `clk` edge. Holding `ptIn[2]` high produces exactly one load.
- R7: `ptIn[0]`=1 or `gSet`=1 forces the register to 1 immediately, without a clock edge.
- R8: `ptIn[1]`=1 forces the register to 0 immediately. When set and clear are both asserted, the clear wins.
- R9: `cfgOeSel` chooses the pin enable: 00 selects `ptIn[4]`, 01 selects `gOe[cfgGoeIdx]`, 10 is always 1, and 11 is always 0.
- R10: `fbData` always equals `pinData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rstN | input | 1 | Global reset, active low, asynchronous |
| gSet | input | 1 | Global set, active high, asynchronous |
| ptIn | input | NUM_SUM+5 | Product terms from the AND array |
| gOe | input | NUM_GOE | Global output enable lines |
| cfgSumMask | input | NUM_SUM | Allocation mask for the sum terms |
| cfgTMode | input | 1 | 1 selects toggle storage, 0 selects D storage |
| cfgCombOut | input | 1 | 1 bypasses the register |
| cfgPtClk | input | 1 | 1 clocks the register from the local clock term |
| cfgOeSel | input | 2 | Source selection for the output enable |
| cfgGoeIdx | input | GOE_W | Index of the global enable line to use |
| pinData | output | 1 | Data driven to the pin |
| pinOe | output | 1 | Enable for the pin driver |
| fbData | output | 1 | Cell output returned to the routing fabric |

## Verification
The hardest situation to reach is a conflict between the asynchronous controls and the clock. This covers clear and set asserted together, and clear released while set is still held. In the second case, nothing changes until the next clock edge picks up the level of the set. The stimulus drives these controls at the falling edge and checks the pin half a cycle before any rising edge, which shows that the response does not depend on the clock. It then lets the scoreboard confirm the state after the edge. The single-load behaviour of the local clock is reached by holding its term high across several cycles while the data changes underneath it.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  // Fixed positions of the local product terms inside the product-term vector
  localparam int PT_SET   = 0;
  localparam int PT_CLR   = 1;
  localparam int PT_CLK   = 2;
  localparam int PT_POL   = 3;
  localparam int PT_OE    = 4;
  localparam int LOCAL_PT = 5;

  typedef enum logic [1:0] {
    OE_PTERM  = 2'b00,
    OE_GLOBAL = 2'b01,
    OE_ON     = 2'b10,
    OE_OFF    = 2'b11
  } oeSrc_e;

  // Strobes handed from control to the datapath register
  typedef struct packed {
    logic loadEn;
    logic asyncSet;
    logic asyncClr;
  } regStrobe_t;

endpackage

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
#(
  parameter int NUM_GOE = 4,
  parameter int GOE_W   = (NUM_GOE > 1) ? $clog2(NUM_GOE) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               gSet,
  input  logic               ptSet,
  input  logic               ptClr,
  input  logic               ptClk,
  input  logic               ptOe,
  input  logic [NUM_GOE-1:0] gOe,
  input  logic               cfgPtClk,
  input  logic [1:0]         cfgOeSel,
  input  logic [GOE_W-1:0]   cfgGoeIdx,
  output regStrobe_t         strobe,
  output logic               oeOut
);

  logic ptClkPrev;
  logic ptClkEdge;
  logic globalOe;
  oeSrc_e oeSrc;

  // Local clock term is sampled on the global clock; a 0->1 step is a load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptClkPrev <= 1'b0;
    else       ptClkPrev <= ptClk;
  end

  assign ptClkEdge = ptClk && !ptClkPrev;

  always_comb begin
    strobe.asyncClr = !rstN || ptClr;
    strobe.asyncSet = gSet || ptSet;
    strobe.loadEn   = cfgPtClk ? ptClkEdge : 1'b1;
  end

  generate
    if ((1 << GOE_W) == NUM_GOE) begin : gFullIdx
      assign globalOe = gOe[cfgGoeIdx];
    end else begin : gGuardIdx
      assign globalOe = (32'(cfgGoeIdx) < NUM_GOE) ? gOe[cfgGoeIdx] : 1'b0;
    end
  endgenerate

  assign oeSrc = oeSrc_e'(cfgOeSel);

  always_comb begin
    unique case (oeSrc)
      OE_PTERM:  oeOut = ptOe;
      OE_GLOBAL: oeOut = globalOe;
      OE_ON:     oeOut = 1'b1;
      default:   oeOut = 1'b0;
    endcase
  end

  // R6: a held local clock term cannot give two loads in a row
  assert_single_ptclk_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPtClk && strobe.loadEn) |=> (!strobe.loadEn || !cfgPtClk));

  // R9: constant-off selection never enables the pin
  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOeSel == 2'b11) |-> !oeOut);

endmodule

// File: rtl/mcell_dpath.sv
module mcell_dpath
  import mcell_pkg::*;
#(
  parameter int NUM_SUM = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SUM-1:0] ptSum,
  input  logic               ptPol,
  input  logic [NUM_SUM-1:0] cfgSumMask,
  input  logic               cfgTMode,
  input  logic               cfgCombOut,
  input  regStrobe_t         strobe,
  output logic               cellOut
);

  logic [NUM_SUM-1:0] allocTerms;
  logic sumTerm;
  logic dataIn;
  logic nextQ;
  logic regQ;
  logic aSet;
  logic aClr;

  generate
    for (genvar i = 0; i < NUM_SUM; i++) begin : gAlloc
      assign allocTerms[i] = ptSum[i] & cfgSumMask[i];
    end
  endgenerate

  assign sumTerm = |allocTerms;
  assign dataIn  = sumTerm ^ ptPol;
  assign nextQ   = cfgTMode ? (regQ ^ dataIn) : dataIn;
  assign aSet    = strobe.asyncSet;
  assign aClr    = strobe.asyncClr;

  // Clear is tested first so it wins over set
  always_ff @(posedge clk or posedge aClr or posedge aSet) begin
    if (aClr)               regQ <= 1'b0;
    else if (aSet)          regQ <= 1'b1;
    else if (strobe.loadEn) regQ <= nextQ;
  end

  assign cellOut = cfgCombOut ? dataIn : regQ;

  // R8: an active clear always leaves the register at 0
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    aClr |-> !regQ);

  // R7: a set held over an edge without clear leaves the register at 1
  assert_set_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (aSet && !aClr) ##1 (aSet && !aClr) |-> regQ);

  // R3: D storage captures the data value
  assert_d_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgTMode && strobe.loadEn && !aSet && !aClr) ##1 (!aSet && !aClr)
      |-> (regQ == $past(dataIn)));

  // R5: T storage flips on a data value of 1
  assert_t_toggle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgTMode && strobe.loadEn && !aSet && !aClr) ##1 (!aSet && !aClr)
      |-> (regQ == ($past(regQ) ^ $past(dataIn))));

  // R6: without a load strobe the register keeps its value
  assert_hold_no_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadEn && !aSet && !aClr) ##1 (!aSet && !aClr) |-> $stable(regQ));

endmodule

// File: rtl/cpld_macrocell.sv
module cpld_macrocell
  import mcell_pkg::*;
#(
  parameter int NUM_SUM = 8,
  parameter int NUM_GOE = 4,
  parameter int GOE_W   = (NUM_GOE > 1) ? $clog2(NUM_GOE) : 1,
  parameter int PT_W    = NUM_SUM + LOCAL_PT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               gSet,
  input  logic [PT_W-1:0]    ptIn,
  input  logic [NUM_GOE-1:0] gOe,
  input  logic [NUM_SUM-1:0] cfgSumMask,
  input  logic               cfgTMode,
  input  logic               cfgCombOut,
  input  logic               cfgPtClk,
  input  logic [1:0]         cfgOeSel,
  input  logic [GOE_W-1:0]   cfgGoeIdx,
  output logic               pinData,
  output logic               pinOe,
  output logic               fbData
);

  regStrobe_t regStrobe;
  logic cellOut;

  mcell_ctrl #(.NUM_GOE(NUM_GOE), .GOE_W(GOE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .gSet      (gSet),
    .ptSet     (ptIn[PT_SET]),
    .ptClr     (ptIn[PT_CLR]),
    .ptClk     (ptIn[PT_CLK]),
    .ptOe      (ptIn[PT_OE]),
    .gOe       (gOe),
    .cfgPtClk  (cfgPtClk),
    .cfgOeSel  (cfgOeSel),
    .cfgGoeIdx (cfgGoeIdx),
    .strobe    (regStrobe),
    .oeOut     (pinOe)
  );

  mcell_dpath #(.NUM_SUM(NUM_SUM)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ptSum      (ptIn[LOCAL_PT +: NUM_SUM]),
    .ptPol      (ptIn[PT_POL]),
    .cfgSumMask (cfgSumMask),
    .cfgTMode   (cfgTMode),
    .cfgCombOut (cfgCombOut),
    .strobe     (regStrobe),
    .cellOut    (cellOut)
  );

  assign pinData = cellOut;
  assign fbData  = cellOut;

endmodule

// File: tb/cpld_macrocell_tb.sv
module cpld_macrocell_tb;
  localparam int NUM_SUM = 8;
  localparam int NUM_GOE = 4;
  localparam int GOE_W   = 2;
  localparam int PT_W    = NUM_SUM + 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, gSet, cfgTMode, cfgCombOut, cfgPtClk;
  logic [PT_W-1:0] ptIn;
  logic [NUM_GOE-1:0] gOe;
  logic [NUM_SUM-1:0] cfgSumMask;
  logic [1:0] cfgOeSel;
  logic [GOE_W-1:0] cfgGoeIdx;
  logic pinData, pinOe, fbData;

  cpld_macrocell u_dut (
    .clk(clk), .rstN(rstN), .gSet(gSet), .ptIn(ptIn), .gOe(gOe),
    .cfgSumMask(cfgSumMask), .cfgTMode(cfgTMode), .cfgCombOut(cfgCombOut),
    .cfgPtClk(cfgPtClk), .cfgOeSel(cfgOeSel), .cfgGoeIdx(cfgGoeIdx),
    .pinData(pinData), .pinOe(pinOe), .fbData(fbData)
  );

  typedef struct { logic data; logic oe; string tag; } exp_t;
  exp_t expQ[$];

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic mq = 1'b0;
  logic mPrev = 1'b0;

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic modelData();
    return (|(ptIn[5 +: NUM_SUM] & cfgSumMask)) ^ ptIn[3];
  endfunction

  function automatic logic modelOe();
    case (cfgOeSel)
      2'b00:   return ptIn[4];
      2'b01:   return gOe[cfgGoeIdx];
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Driver: inputs already set at a falling edge; predict state after the next rising edge
  task automatic cycle(string tag);
    logic d, load, clr, set;
    exp_t e;
    clr  = !rstN || ptIn[1];
    set  = gSet || ptIn[0];
    d    = modelData();
    load = cfgPtClk ? (ptIn[2] && !mPrev) : 1'b1;
    if (clr)       mq = 1'b0;
    else if (set)  mq = 1'b1;
    else if (load) mq = cfgTMode ? (mq ^ d) : d;
    mPrev = rstN ? ptIn[2] : 1'b0;
    e.data = cfgCombOut ? d : mq;
    e.oe   = modelOe();
    e.tag  = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // Mid-cycle check, far from any rising edge
  task automatic midCheck(string tag, logic exp);
    #1;
    check(tag, pinData, exp);
  endtask

  // Monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(e.tag, pinData, e.data);
        check({e.tag, " R10 feedback"}, fbData, pinData);
        check({e.tag, " oe"}, pinOe, e.oe);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; gSet = 1'b0; ptIn = '0; gOe = '0;
    cfgSumMask = '0; cfgTMode = 1'b0; cfgCombOut = 1'b0; cfgPtClk = 1'b0;
    cfgOeSel = 2'b10; cfgGoeIdx = '0;
    @(negedge clk);
    // R1: reset holds the register low even with data 1
    cfgSumMask = 8'h0F; ptIn[5] = 1'b1;
    cycle("R1 reset");
    cycle("R1 reset hold");
    rstN = 1'b1;

    // R3 / R2: D storage on the global clock
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h01; cycle("R3 load 1");
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h10; cycle("R2 masked term ignored");
    ptIn = '0; ptIn[3] = 1'b1;             cycle("R2 polarity inverts 0");
    ptIn = '0; ptIn[3] = 1'b1; ptIn[5 +: NUM_SUM] = 8'h02; cycle("R2 polarity inverts 1");
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h08; cycle("R3 load high term");

    // R4: combinational bypass
    cfgCombOut = 1'b1;
    ptIn = '0; midCheck("R4 comb follows 0", 1'b0); cycle("R4 comb 0");
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h04; midCheck("R4 comb follows 1", 1'b1); cycle("R4 comb 1");
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h04; ptIn[3] = 1'b1; midCheck("R4 comb polarity", 1'b0); cycle("R4 comb pol");
    cfgCombOut = 1'b0;

    // R5: toggle storage
    cfgTMode = 1'b1;
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h01; cycle("R5 toggle a");
    cycle("R5 toggle b");
    cycle("R5 toggle c");
    ptIn = '0; cycle("R5 hold a");
    cycle("R5 hold b");
    ptIn = '0; ptIn[3] = 1'b1; cycle("R5 toggle via polarity");
    cfgTMode = 1'b0;

    // R6: local clock term
    cfgPtClk = 1'b1;
    ptIn = '0; cycle("R6 clr data no edge");
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h01; cycle("R6 no edge hold");
    ptIn = '0; ptIn[5 +: NUM_SUM] = 8'h01; ptIn[2] = 1'b1; cycle("R6 edge loads 1");
    ptIn = '0; ptIn[2] = 1'b1; cycle("R6 held high no load");
    cycle("R6 held high no load again");
    ptIn = '0; cycle("R6 low no load");
    ptIn = '0; ptIn[2] = 1'b1; cycle("R6 second edge loads 0");

    // R7 / R8: asynchronous controls
    ptIn = '0; ptIn[0] = 1'b1; midCheck("R7 set without edge", 1'b1); cycle("R7 set");
    ptIn = '0; ptIn[1] = 1'b1; midCheck("R8 clear without edge", 1'b0); cycle("R8 clear");
    ptIn = '0; gSet = 1'b1; midCheck("R7 global set without edge", 1'b1); cycle("R7 global set");
    gSet = 1'b0;
    ptIn = '0; ptIn[0] = 1'b1; ptIn[1] = 1'b1; midCheck("R8 clear beats set", 1'b0); cycle("R8 both");
    ptIn = '0; ptIn[0] = 1'b1; midCheck("R8 clear released set level", 1'b0); cycle("R7 set level at edge");
    ptIn = '0; cycle("R7 release");
    cfgPtClk = 1'b0;

    // R9: enable source selection
    cfgOeSel = 2'b00; ptIn = '0; ptIn[4] = 1'b1; cycle("R9 pterm oe 1");
    ptIn = '0; cycle("R9 pterm oe 0");
    cfgOeSel = 2'b01; gOe = 4'b0100; cfgGoeIdx = 2'd2; cycle("R9 global idx2");
    cfgGoeIdx = 2'd1; cycle("R9 global idx1");
    gOe = 4'b1000; cfgGoeIdx = 2'd3; cycle("R9 global idx3");
    cfgOeSel = 2'b10; gOe = '0; cycle("R9 always on");
    cfgOeSel = 2'b11; ptIn = '0; ptIn[4] = 1'b1; gOe = '1; cycle("R9 always off");

    // R1: reset in mid operation
    cfgOeSel = 2'b10; ptIn = '0; ptIn[0] = 1'b1; cycle("R7 set before reset");
    ptIn = '0; rstN = 1'b0; midCheck("R1 async reset", 1'b0); cycle("R1 reset again");
    rstN = 1'b1; cycle("R1 after reset");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule